// File: doc/BRIEF.md
# Microcode Start-Address Selector with Condition Evaluation

This block sits between the instruction-property table and the microcode sequencer. For every instruction it works out two condition bits and uses them to choose the first microcode address that the sequencer loads. The two bits come from one of two condition sets. In the status-test set, a 3-bit selector field of the instruction picks one of eight status bits. A second test asks whether the low field of the instruction is all zero. In the variant set, the two lowest instruction bits act directly as a 2-bit variant number. A per-instruction flag chooses the set.

The condition pair then chooses the start address. When both bits are clear, the 7-bit default start address passes through unchanged. Otherwise the upper four bits of the default address are kept, and the low three bits are replaced by one of three alternate fields. An instruction can therefore branch to a different microcode entry, or to one of up to four variants, without a separate jump step. The block registers its outputs once, so results appear one clock after the inputs.

Top module: `ucode_start_sel`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `start_addr_o`, `cond1_o` and `cond2_o` are all 0 after that edge.
- R2: Outputs are registered. A change on any data input shows on the outputs after the next rising edge and not before it.
- R3: With `alt_set_i` = 0 (status-test set), `cond1_o` equals `status_i[field_i[5:3]]`, taking the selector field as an unsigned index 0..7.
- R4: With `alt_set_i` = 0, `cond2_o` is 1 exactly when `field_i[2:0]` is 000.
- R5: With `alt_set_i` = 1 (variant set), `cond1_o` equals `field_i[1]` and `cond2_o` equals `field_i[0]`.
- R6: When the condition pair {cond1, cond2} is 00, `start_addr_o` equals `dflt_addr_i` in full.
- R7: When the pair is 01, 10 or 11, `start_addr_o` is {`dflt_addr_i[6:3]`, low}. The low part is `alt1_low_i`, `alt2_low_i` or `alt3_low_i` respectively.
- R8: With `alt_set_i` = 0, status bits other than the selected one have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| field_i | input | 6 | Instruction condition field: [5:3] selector, [2:0] low field |
| status_i | input | 8 | Status-register bits |
| alt_set_i | input | 1 | 0 = status-test set, 1 = variant set |
| dflt_addr_i | input | 7 | Default microcode start address |
| alt1_low_i | input | 3 | Low bits used when the pair is 01 |
| alt2_low_i | input | 3 | Low bits used when the pair is 10 |
| alt3_low_i | input | 3 | Low bits used when the pair is 11 |
| start_addr_o | output | 7 | Selected microcode start address |
| cond1_o | output | 1 | Registered condition 1 |
| cond2_o | output | 1 | Registered condition 2 |

## Verification
The bench builds the block with its default parameters: a 3-bit selector, a 3-bit low field, a 7-bit address and 3-bit alternate fields. At these values all eight decoded selector lines and every status bit can be reached exhaustively. All four condition pairs, and therefore every address path, are reachable in both condition sets. Directed one-hot and inverted status patterns are mixed with random vectors. Together they cover the zero-field test, the status-mask independence and the one-cycle output timing.

// File: rtl/cond_sel_pkg.sv
package cond_sel_pkg;

    // Which rule set produces the two condition bits.
    typedef enum logic {
        SET_STATUS  = 1'b0,
        SET_VARIANT = 1'b1
    } cond_set_e;

    // Condition pair carried between the evaluators and the address mux.
    typedef struct packed {
        logic c1;
        logic c2;
    } cond_pair_t;

    // Address path selected by the condition pair {c1, c2}.
    typedef enum logic [1:0] {
        PATH_DEFAULT = 2'b00,
        PATH_ALT1    = 2'b01,
        PATH_ALT2    = 2'b10,
        PATH_ALT3    = 2'b11
    } path_e;

    function automatic path_e pair_to_path(input cond_pair_t p);
        return path_e'({p.c1, p.c2});
    endfunction

endpackage

// File: rtl/cond_status_eval.sv
module cond_status_eval
    import cond_sel_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int ZERO_W = 3
) (
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [(1<<SEL_W)-1:0]   status_i,
    input  logic [ZERO_W-1:0]       low_i,
    output cond_pair_t              pair_o
);
    localparam int LINES = 1 << SEL_W;

    logic [LINES-1:0] line_hot;
    logic [LINES-1:0] line_gated;

    // One decoded line per status bit; each line gates only its own bit.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign line_hot[g]   = (sel_i == SEL_W'(g));
        assign line_gated[g] = line_hot[g] & status_i[g];
    end

    assign pair_o.c1 = |line_gated;
    assign pair_o.c2 = (low_i == '0);

endmodule

// File: rtl/cond_variant_eval.sv
module cond_variant_eval
    import cond_sel_pkg::*;
(
    input  logic [1:0] variant_i,
    output cond_pair_t pair_o
);
    assign pair_o.c1 = variant_i[1];
    assign pair_o.c2 = variant_i[0];
endmodule

// File: rtl/start_addr_mux.sv
module start_addr_mux
    import cond_sel_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int LOW_W  = 3
) (
    input  path_e              path_i,
    input  logic [ADDR_W-1:0]  dflt_i,
    input  logic [LOW_W-1:0]   alt1_i,
    input  logic [LOW_W-1:0]   alt2_i,
    input  logic [LOW_W-1:0]   alt3_i,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam int HI_W = ADDR_W - LOW_W;

    logic [HI_W-1:0] hi_part;
    assign hi_part = dflt_i[ADDR_W-1:LOW_W];

    always_comb begin
        unique case (path_i)
            PATH_ALT1: addr_o = {hi_part, alt1_i};
            PATH_ALT2: addr_o = {hi_part, alt2_i};
            PATH_ALT3: addr_o = {hi_part, alt3_i};
            default:   addr_o = dflt_i;
        endcase
    end

endmodule

// File: rtl/ucode_start_sel.sv
module ucode_start_sel
    import cond_sel_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int ZERO_W = 3,
    parameter int ADDR_W = 7,
    parameter int LOW_W  = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [SEL_W+ZERO_W-1:0]       field_i,
    input  logic [(1<<SEL_W)-1:0]         status_i,
    input  logic                          alt_set_i,
    input  logic [ADDR_W-1:0]             dflt_addr_i,
    input  logic [LOW_W-1:0]              alt1_low_i,
    input  logic [LOW_W-1:0]              alt2_low_i,
    input  logic [LOW_W-1:0]              alt3_low_i,
    output logic [ADDR_W-1:0]             start_addr_o,
    output logic                          cond1_o,
    output logic                          cond2_o
);
    localparam int FIELD_W = SEL_W + ZERO_W;

    cond_pair_t        pair_status;
    cond_pair_t        pair_variant;
    cond_pair_t        pair_sel;
    cond_set_e         set_sel;
    logic [ADDR_W-1:0] addr_next;

    cond_pair_t        pair_q;
    logic [ADDR_W-1:0] addr_q;

    cond_status_eval #(
        .SEL_W  (SEL_W),
        .ZERO_W (ZERO_W)
    ) u_status (
        .sel_i    (field_i[FIELD_W-1:ZERO_W]),
        .status_i (status_i),
        .low_i    (field_i[ZERO_W-1:0]),
        .pair_o   (pair_status)
    );

    cond_variant_eval u_variant (
        .variant_i (field_i[1:0]),
        .pair_o    (pair_variant)
    );

    assign set_sel  = cond_set_e'(alt_set_i);
    assign pair_sel = (set_sel == SET_VARIANT) ? pair_variant : pair_status;

    start_addr_mux #(
        .ADDR_W (ADDR_W),
        .LOW_W  (LOW_W)
    ) u_mux (
        .path_i (pair_to_path(pair_sel)),
        .dflt_i (dflt_addr_i),
        .alt1_i (alt1_low_i),
        .alt2_i (alt2_low_i),
        .alt3_i (alt3_low_i),
        .addr_o (addr_next)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pair_q <= '0;
            addr_q <= '0;
        end else begin
            pair_q <= pair_sel;
            addr_q <= addr_next;
        end
    end

    assign start_addr_o = addr_q;
    assign cond1_o      = pair_q.c1;
    assign cond2_o      = pair_q.c2;

endmodule

// File: rtl/ucode_start_sel_chk.sv
module ucode_start_sel_chk #(
    parameter int SEL_W  = 3,
    parameter int ZERO_W = 3,
    parameter int ADDR_W = 7,
    parameter int LOW_W  = 3
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic [SEL_W+ZERO_W-1:0]  field_i,
    input logic [(1<<SEL_W)-1:0]    status_i,
    input logic                     alt_set_i,
    input logic [ADDR_W-1:0]        dflt_addr_i,
    input logic [ADDR_W-1:0]        start_addr_o,
    input logic                     cond1_o,
    input logic                     cond2_o
);
    localparam int FIELD_W = SEL_W + ZERO_W;

    logic live;
    logic picked_bit;
    logic low_zero;

    assign picked_bit = status_i[field_i[FIELD_W-1:ZERO_W]];
    assign low_zero   = (field_i[ZERO_W-1:0] == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) live <= 1'b0;
        else       live <= 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk_i)
        rst_i |=> (start_addr_o == '0) && !cond1_o && !cond2_o);

    a_r3_status_pick: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && !$past(alt_set_i)) |-> (cond1_o == $past(picked_bit)));

    a_r4_zero_test: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && !$past(alt_set_i)) |-> (cond2_o == $past(low_zero)));

    a_r5_variant_bits: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && $past(alt_set_i)) |->
            (cond1_o == $past(field_i[1])) && (cond2_o == $past(field_i[0])));

    a_r6_default_path: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && !cond1_o && !cond2_o) |-> (start_addr_o == $past(dflt_addr_i)));

    a_r7_upper_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (live && (cond1_o || cond2_o)) |->
            (start_addr_o[ADDR_W-1:LOW_W] == $past(dflt_addr_i[ADDR_W-1:LOW_W])));

endmodule

bind ucode_start_sel ucode_start_sel_chk #(
    .SEL_W  (SEL_W),
    .ZERO_W (ZERO_W),
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .field_i      (field_i),
    .status_i     (status_i),
    .alt_set_i    (alt_set_i),
    .dflt_addr_i  (dflt_addr_i),
    .start_addr_o (start_addr_o),
    .cond1_o      (cond1_o),
    .cond2_o      (cond2_o)
);

// File: tb/ucode_start_sel_tb_top.sv
module ucode_start_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] field;
    logic [7:0] status;
    logic       alt_set;
    logic [6:0] dflt;
    logic [2:0] a1, a2, a3;
    logic [6:0] addr_o;
    logic       c1_o, c2_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ucode_start_sel dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .field_i      (field),
        .status_i     (status),
        .alt_set_i    (alt_set),
        .dflt_addr_i  (dflt),
        .alt1_low_i   (a1),
        .alt2_low_i   (a2),
        .alt3_low_i   (a3),
        .start_addr_o (addr_o),
        .cond1_o      (c1_o),
        .cond2_o      (c2_o)
    );

    // Expected {addr[6:0], c1, c2} from the requirements.
    function automatic logic [8:0] model(input logic [5:0] f, input logic [7:0] s,
                                         input logic alt, input logic [6:0] d,
                                         input logic [2:0] x1, input logic [2:0] x2,
                                         input logic [2:0] x3);
        logic e1, e2;
        logic [6:0] ea;
        if (alt) begin
            e1 = f[1];
            e2 = f[0];
        end else begin
            e1 = s[f[5:3]];
            e2 = (f[2:0] == 3'b000);
        end
        case ({e1, e2})
            2'b00:   ea = d;
            2'b01:   ea = {d[6:3], x1};
            2'b10:   ea = {d[6:3], x2};
            default: ea = {d[6:3], x3};
        endcase
        return {ea, e1, e2};
    endfunction

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got addr=%0h c1=%0b c2=%0b, expected addr=%0h c1=%0b c2=%0b",
                     tag, got[8:2], got[1], got[0], exp[8:2], exp[1], exp[0]);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic apply(input string tag, input logic [5:0] f, input logic [7:0] s,
                         input logic alt, input logic [6:0] d,
                         input logic [2:0] x1, input logic [2:0] x2, input logic [2:0] x3);
        @(negedge clk);
        field = f; status = s; alt_set = alt; dflt = d; a1 = x1; a2 = x2; a3 = x3;
        @(negedge clk);
        check(tag, {addr_o, c1_o, c2_o}, model(f, s, alt, d, x1, x2, x3));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] prev;
        process::self().srandom(32'd2024);
        rst = 1'b1;
        field = 6'h15; status = 8'hFF; alt_set = 1'b0; dflt = 7'h5A;
        a1 = 3'd1; a2 = 3'd2; a3 = 3'd3;
        repeat (3) @(negedge clk);
        check("R1 reset", {addr_o, c1_o, c2_o}, 9'd0);
        rst = 1'b0;

        // R3: each selector value with a single status bit set, and with it cleared
        for (int i = 0; i < 8; i++) begin
            apply("R3 onehot", {i[2:0], 3'b101}, 8'(1 << i), 1'b0, 7'h6C, 3'd1, 3'd2, 3'd3);
            apply("R3 inverted", {i[2:0], 3'b101}, ~8'(1 << i), 1'b0, 7'h6C, 3'd1, 3'd2, 3'd3);
        end

        // R4 and R7: zero low field with both status values
        apply("R4 zero low, bit clear", 6'b010_000, 8'h00, 1'b0, 7'h7F, 3'd4, 3'd5, 3'd6);
        apply("R4 zero low, bit set R7", 6'b010_000, 8'h04, 1'b0, 7'h7F, 3'd4, 3'd5, 3'd6);
        apply("R4 nonzero low R6", 6'b010_100, 8'h00, 1'b0, 7'h33, 3'd4, 3'd5, 3'd6);

        // R5 and R7: all four variants
        for (int v = 0; v < 4; v++)
            apply("R5 variant R7", {4'b1110, v[1:0]}, 8'h00, 1'b1, 7'h48, 3'd7, 3'd0, 3'd5);

        // R6: default path keeps all seven bits
        apply("R6 default", 6'b000_001, 8'hFE, 1'b0, 7'h55, 3'd0, 3'd0, 3'd0);

        // R2: a new input does not reach the outputs before the rising edge
        apply("R2 setup", 6'b000_001, 8'h00, 1'b0, 7'h11, 3'd0, 3'd0, 3'd0);
        prev = {addr_o, c1_o, c2_o};
        @(negedge clk);
        field = 6'b000_011; alt_set = 1'b1; dflt = 7'h22; a3 = 3'd6;
        #2;
        check("R2 before edge", {addr_o, c1_o, c2_o}, prev);
        @(negedge clk);
        check("R2 after edge", {addr_o, c1_o, c2_o},
              model(6'b000_011, 8'h00, 1'b1, 7'h22, 3'd0, 3'd0, 3'd6));

        // R8: unselected status bits are flipped, outputs stay put
        for (int i = 0; i < 8; i++) begin
            apply("R8 base", {i[2:0], 3'b011}, 8'(1 << i), 1'b0, 7'h3C, 3'd1, 3'd2, 3'd3);
            prev = {addr_o, c1_o, c2_o};
            apply("R8 others flipped", {i[2:0], 3'b011}, 8'hFF, 1'b0, 7'h3C, 3'd1, 3'd2, 3'd3);
            check("R8 unchanged", {addr_o, c1_o, c2_o}, prev);
        end

        // Random mix covering R3..R7
        for (int k = 0; k < 400; k++)
            apply("R3-R7 random mix", 6'($urandom), 8'($urandom), 1'($urandom), 7'($urandom),
                  3'($urandom), 3'($urandom), 3'($urandom));

        // R1 again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", {addr_o, c1_o, c2_o}, 9'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule